// File: doc/BRIEF.md
# Hash Engine Register Front-End

This block is the register-mapped control and status front-end of a multi-algorithm hash engine. Software uses a simple 32-bit register bus to do four things: hold the block in soft reset, program the message length in bits, and select the algorithm and the byte lane order. It then streams message words into a separate data port. Each accepted word has its byte lanes reordered and is forwarded to the compression core over a valid/ready channel. Each word carries a per-lane byte-valid mask and a last flag, and both come from the programmed length. The data port itself has no byte mask.

When the core hands back a digest, all of its words load into a result queue at once. Software pops the queue one word per read. Sticky status bits report four conditions: a new digest, a queue that holds data, a read of an empty queue, and data written before configuration or past the end of the message. Each status bit can raise the interrupt pin when its enable bit is set.

Back-pressure rules: the data port and the core channel are combinational pass-throughs. While a word may be forwarded, `dat_ready` follows `core_ready`, and `core_valid` follows `dat_valid`. Once `dat_valid` is raised, the upstream must hold the word stable until `dat_ready` is seen high at a clock edge. A word that will be dropped is accepted at once, with `dat_ready` high. The digest channel is accepted only while the result queue is empty.

Top module: `hsh_front`

## Requirements
- R1: After `rst_n` low, and again after a soft reset has been released, every register reads 0, `irq` is low, `core_valid` is low and the result queue is empty.
- R2: Writing 1 to bit 0 at address 0x00 holds the block in soft reset until 0 is written there. While the block is held, writes to other registers are ignored, result-queue reads return 0 with no error, data words are accepted and discarded without error, and `dig_ready` is low.
- R3: The message length in bits is written at 0x04 (bits 63:32) and 0x08 (bits 31:0). The number of message bytes is ceil(bits/8).
- R4: Control at 0x0C: bits [1:0] select the algorithm (0 MD5, 1 SHA-1, 2 SHA-224, 3 SHA-256) and drive `core_algo`. Bits [9:8] select the lane order. Bytes are named by input lane, where lane k is bits [8k+7:8k]. The forwarded word, listed from its top byte to its bottom byte, is 3,2,1,0 for order 0, 0,1,2,3 for order 1, 2,3,1,0 for order 2, and 1,0,3,2 for order 3.
- R5: In the two cycles that follow a control write, `dat_ready` is low and no word is taken. A control write also restarts the byte count.
- R6: A forwarded word passes to the core only when `core_valid` and `core_ready` are both high at an edge. Words reach the core in the order they arrived, each exactly once.
- R7: `core_ben` bit j marks output lane j (bits [8j+7:8j]) as message data. The mask is all ones while 4 or more bytes remain; otherwise only the lowest "remaining" lanes are set. `core_last` is high on the word that takes the final bytes.
- R8: A data word that arrives before any control write since reset, or after all message bytes have been taken, is accepted, is not forwarded, and sets status bit 3.
- R9: A digest is taken only while the queue is empty (`dig_ready` high). It loads 4, 5, 7 or 8 words for algorithms 0 to 3, taken from `dig_words[32i+31:32i]`. Reads at 0x1C return those words in ascending order i.
- R10: A read at 0x1C while the queue is empty returns 0 and sets status bit 2.
- R11: Status at 0x10: bit 0 is high while the queue holds words, bit 1 sets when a digest loads, bits 1 to 3 are sticky, and writing a mask at 0x18 clears the matching bits 1 to 3. If a set and a clear of the same bit fall in one cycle, the set wins.
- R12: `irq` is high when any of status bits 3:0 is set together with its enable bit at 0x14 (bits 3:0). Status bit 8 reads the value of `irq`.
- R13: `bus_rdata` is updated at the edge that ends a read request and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous-free active-low reset, sampled on clk |
| bus_sel | input | 1 | register access request this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 5 | byte address of the register |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, registered |
| dat_valid | input | 1 | message word offered |
| dat_ready | output | 1 | message word taken at this edge |
| dat_word | input | 32 | message word |
| core_valid | output | 1 | reordered word offered to the core |
| core_ready | input | 1 | core takes the word |
| core_data | output | 32 | reordered word |
| core_ben | output | 4 | per-lane message-byte mask |
| core_last | output | 1 | word carries the final message bytes |
| core_algo | output | 2 | selected algorithm |
| dig_valid | input | 1 | core offers a digest |
| dig_ready | output | 1 | digest taken at this edge |
| dig_words | input | 256 | digest words, word i at bits [32i+31:32i] |
| irq | output | 1 | interrupt request |

## Verification
A digest load can fall in the same cycle as a status clear. It can also fall in the same cycle as a result-queue read. The bench provokes the first case by placing a clear of bit 1 and a digest handshake in one cycle; the status must still show bit 1, and a later clear on its own must remove it. It provokes the second case by issuing a queue read in the cycle a digest loads into an empty queue. That read must return 0 and raise the read-error bit, and all digest words must still come out afterwards, in order.

// File: rtl/hsh_pkg.sv
package hsh_pkg;

  typedef enum logic [1:0] {
    ALG_MD5    = 2'd0,
    ALG_SHA1   = 2'd1,
    ALG_SHA224 = 2'd2,
    ALG_SHA256 = 2'd3
  } hsh_alg_e;

  localparam int DIG_MAX  = 8;
  localparam int WORD_W   = 32;
  localparam int LANES    = 4;

  localparam logic [4:0] A_RST   = 5'h00;
  localparam logic [4:0] A_LENH  = 5'h04;
  localparam logic [4:0] A_LENL  = 5'h08;
  localparam logic [4:0] A_CTRL  = 5'h0C;
  localparam logic [4:0] A_STAT  = 5'h10;
  localparam logic [4:0] A_EN    = 5'h14;
  localparam logic [4:0] A_CLR   = 5'h18;
  localparam logic [4:0] A_RQ    = 5'h1C;

  // digest length in words for each algorithm
  function automatic logic [3:0] dig_count(hsh_alg_e alg);
    case (alg)
      ALG_MD5:    return 4'd4;
      ALG_SHA1:   return 4'd5;
      ALG_SHA224: return 4'd7;
      default:    return 4'd8;
    endcase
  endfunction

  // input lane that feeds output lane j under a given order
  function automatic logic [1:0] src_lane(logic [1:0] order, logic [1:0] j);
    case (order)
      2'd0:    return j;
      2'd1:    return 2'd3 - j;
      2'd2:    return (j == 2'd3) ? 2'd2 : (j == 2'd2) ? 2'd3 : j;
      default: return j ^ 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/hsh_lane_swap.sv
module hsh_lane_swap
  import hsh_pkg::*;
(
  input  logic [1:0]          order_i,
  input  logic [WORD_W-1:0]   word_i,
  output logic [WORD_W-1:0]   word_o
);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [1:0] src;
    assign src = src_lane(order_i, 2'(j));
    assign word_o[8*j +: 8] = word_i[{src, 3'b000} +: 8];
  end

endmodule

// File: rtl/hsh_feed.sv
module hsh_feed
  import hsh_pkg::*;
#(
  parameter int LEN_W = 64,
  parameter int GUARD = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hold_i,
  input  logic                cfg_we_i,
  input  logic [LEN_W-1:0]    len_bits_i,
  input  logic [1:0]          order_i,
  input  logic                dat_valid_i,
  output logic                dat_ready_o,
  input  logic [WORD_W-1:0]   dat_word_i,
  output logic                core_valid_o,
  input  logic                core_ready_i,
  output logic [WORD_W-1:0]   core_data_o,
  output logic [LANES-1:0]    core_ben_o,
  output logic                core_last_o,
  output logic                wr_err_o
);

  localparam int CW = LEN_W - 2;
  localparam int GW = $clog2(GUARD + 1);

  logic          cfg_q;
  logic [GW-1:0] guard_q;
  logic [CW-1:0] sent_q;
  logic [CW-1:0] need, rem, step;
  logic          full, have, guard_busy, fwd, fire;

  // bytes in the message: ceil(bits / 8)
  assign need       = CW'(len_bits_i[LEN_W-1:3]) + CW'(|len_bits_i[2:0]);
  assign rem        = need - sent_q;
  assign full       = rem >= CW'(LANES);
  assign have       = rem != '0;
  assign guard_busy = guard_q != '0;
  assign fwd        = cfg_q && !hold_i && !guard_busy && have;
  assign step       = full ? CW'(LANES) : CW'(rem[2:0]);

  always_comb begin
    if (hold_i || !cfg_q)  dat_ready_o = 1'b1;
    else if (guard_busy)   dat_ready_o = 1'b0;
    else if (!have)        dat_ready_o = 1'b1;
    else                   dat_ready_o = core_ready_i;
  end

  assign core_valid_o = dat_valid_i && fwd;
  assign fire         = core_valid_o && core_ready_i;
  assign wr_err_o     = dat_valid_i && dat_ready_o && !hold_i && !fwd;
  assign core_last_o  = rem <= CW'(LANES);

  for (genvar k = 0; k < LANES; k++) begin : g_ben
    assign core_ben_o[k] = full || (rem[2:0] > 3'(k));
  end

  hsh_lane_swap u_swap (
    .order_i (order_i),
    .word_i  (dat_word_i),
    .word_o  (core_data_o)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni || hold_i) begin
      cfg_q   <= 1'b0;
      guard_q <= '0;
      sent_q  <= '0;
    end else if (cfg_we_i) begin
      cfg_q   <= 1'b1;
      guard_q <= GW'(GUARD);
      sent_q  <= '0;
    end else begin
      if (guard_busy) guard_q <= guard_q - 1'b1;
      if (fire)       sent_q  <= sent_q + step;
    end
  end

  p_guard_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !dat_ready_o);

  p_unconf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_valid_o |-> cfg_q);

  p_ben_shape_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_valid_o |-> (core_ben_o[0] && (core_last_o || core_ben_o == '1)));

endmodule

// File: rtl/hsh_result_q.sv
module hsh_result_q #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    load_i,
  input  logic [$clog2(DEPTH+1)-1:0] load_n_i,
  input  logic [DEPTH*W-1:0]      load_data_i,
  input  logic                    pop_i,
  output logic                    empty_o,
  output logic [W-1:0]            head_o
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rptr_q;
  logic [CW-1:0] cnt_q;

  assign empty_o = cnt_q == '0;
  assign head_o  = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clr_i) begin
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      rptr_q <= '0;
      cnt_q  <= load_n_i;
    end else if (pop_i) begin
      rptr_q <= rptr_q + 1'b1;
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_mem
    always_ff @(posedge clk_i) begin
      if (load_i) mem_q[i] <= load_data_i[i*W +: W];
    end
  end

  p_load_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> empty_o);

  p_pop_dec_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !clr_i && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_cnt_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/hsh_front.sv
module hsh_front
  import hsh_pkg::*;
#(
  parameter int GUARD = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic [4:0]                bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic                      dat_valid,
  output logic                      dat_ready,
  input  logic [31:0]               dat_word,
  output logic                      core_valid,
  input  logic                      core_ready,
  output logic [31:0]               core_data,
  output logic [3:0]                core_ben,
  output logic                      core_last,
  output logic [1:0]                core_algo,
  input  logic                      dig_valid,
  output logic                      dig_ready,
  input  logic [DIG_MAX*WORD_W-1:0] dig_words,
  output logic                      irq
);

  localparam int LEN_W = 64;
  localparam int QCW   = $clog2(DIG_MAX + 1);

  logic        srst_q;
  logic [31:0] len_hi_q, len_lo_q;
  hsh_alg_e    alg_q;
  logic [1:0]  ord_q;
  logic [3:0]  en_q;
  logic [3:1]  stat_q;
  logic [31:0] rdata_q;

  logic        wr_go, rd_go, wr_cfg, ctrl_we;
  logic        q_empty, rq_rd, rq_pop, rq_err, dig_fire, wr_err;
  logic [31:0] q_head, rd_mux;
  logic [3:0]  stat_vec;
  logic [3:1]  stat_set, stat_clr;
  logic        irq_w;

  assign wr_go    = bus_sel && bus_wr;
  assign rd_go    = bus_sel && !bus_wr;
  assign wr_cfg   = wr_go && !srst_q;
  assign ctrl_we  = wr_cfg && (bus_addr == A_CTRL);
  assign rq_rd    = rd_go && (bus_addr == A_RQ) && !srst_q;
  assign rq_pop   = rq_rd && !q_empty;
  assign rq_err   = rq_rd && q_empty;
  assign dig_ready = q_empty && !srst_q;
  assign dig_fire = dig_valid && dig_ready;

  assign stat_vec = {stat_q, !q_empty};
  assign irq_w    = |(stat_vec & en_q);
  assign irq      = irq_w;
  assign core_algo = alg_q;
  assign bus_rdata = rdata_q;

  assign stat_set = {wr_err, rq_err, dig_fire};
  assign stat_clr = (wr_cfg && bus_addr == A_CLR) ? bus_wdata[3:1] : 3'b000;

  hsh_feed #(.LEN_W(LEN_W), .GUARD(GUARD)) u_feed (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .hold_i       (srst_q),
    .cfg_we_i     (ctrl_we),
    .len_bits_i   ({len_hi_q, len_lo_q}),
    .order_i      (ord_q),
    .dat_valid_i  (dat_valid),
    .dat_ready_o  (dat_ready),
    .dat_word_i   (dat_word),
    .core_valid_o (core_valid),
    .core_ready_i (core_ready),
    .core_data_o  (core_data),
    .core_ben_o   (core_ben),
    .core_last_o  (core_last),
    .wr_err_o     (wr_err)
  );

  hsh_result_q #(.W(WORD_W), .DEPTH(DIG_MAX)) u_rq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .clr_i       (srst_q),
    .load_i      (dig_fire),
    .load_n_i    (QCW'(dig_count(alg_q))),
    .load_data_i (dig_words),
    .pop_i       (rq_pop),
    .empty_o     (q_empty),
    .head_o      (q_head)
  );

  always_comb begin
    case (bus_addr)
      A_RST:   rd_mux = {31'b0, srst_q};
      A_LENH:  rd_mux = len_hi_q;
      A_LENL:  rd_mux = len_lo_q;
      A_CTRL:  rd_mux = {22'b0, ord_q, 6'b0, alg_q};
      A_STAT:  rd_mux = {23'b0, irq_w, 4'b0, stat_vec};
      A_EN:    rd_mux = {28'b0, en_q};
      A_RQ:    rd_mux = rq_pop ? q_head : 32'b0;
      default: rd_mux = 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srst_q   <= 1'b0;
      len_hi_q <= '0;
      len_lo_q <= '0;
      alg_q    <= ALG_MD5;
      ord_q    <= '0;
      en_q     <= '0;
      stat_q   <= '0;
      rdata_q  <= '0;
    end else begin
      if (wr_go && bus_addr == A_RST) srst_q <= bus_wdata[0];
      if (rd_go) rdata_q <= rd_mux;
      if (srst_q) begin
        len_hi_q <= '0;
        len_lo_q <= '0;
        alg_q    <= ALG_MD5;
        ord_q    <= '0;
        en_q     <= '0;
        stat_q   <= '0;
      end else begin
        if (wr_cfg && bus_addr == A_LENH) len_hi_q <= bus_wdata;
        if (wr_cfg && bus_addr == A_LENL) len_lo_q <= bus_wdata;
        if (ctrl_we) begin
          alg_q <= hsh_alg_e'(bus_wdata[1:0]);
          ord_q <= bus_wdata[9:8];
        end
        if (wr_cfg && bus_addr == A_EN) en_q <= bus_wdata[3:0];
        stat_q <= (stat_q & ~stat_clr) | stat_set;
      end
    end
  end

  p_newres_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dig_fire |=> stat_q[1]);

  p_rderr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rq_err |=> stat_q[2]);

  p_hold_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |-> (!core_valid && dat_ready && !dig_ready));

  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> $stable(bus_rdata));

endmodule

// File: tb/hsh_front_bench.sv
module hsh_front_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         dat_valid = 1'b0;
  logic         dat_ready;
  logic [31:0]  dat_word = '0;
  logic         core_valid;
  logic         core_ready = 1'b1;
  logic [31:0]  core_data;
  logic [3:0]   core_ben;
  logic         core_last;
  logic [1:0]   core_algo;
  logic         dig_valid = 1'b0;
  logic         dig_ready;
  logic [255:0] dig_words = '0;
  logic         irq;

  always #2 clk = ~clk;

  hsh_front u_hsh_front (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_word(dat_word),
    .core_valid(core_valid), .core_ready(core_ready), .core_data(core_data),
    .core_ben(core_ben), .core_last(core_last), .core_algo(core_algo),
    .dig_valid(dig_valid), .dig_ready(dig_ready), .dig_words(dig_words),
    .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [36:0] exp_q[$];
  bit     m_cfg = 0, m_hold = 0, bp_on = 0;
  int     m_ord = 0;
  longint m_bits = 0, m_rem = 0;
  int     bp_cnt = 0;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] ref_swap(input int ord, input logic [31:0] w);
    logic [7:0] b0, b1, b2, b3;
    {b3, b2, b1, b0} = w;
    case (ord)
      0:       return w;
      1:       return {b0, b1, b2, b3};
      2:       return {b2, b3, b1, b0};
      default: return {b1, b0, b3, b2};
    endcase
  endfunction

  // back-pressure pattern on the core channel (R6)
  initial forever begin
    @(posedge clk); #1;
    bp_cnt++;
    core_ready = bp_on ? (bp_cnt % 3 != 0) : 1'b1;
  end

  // scoreboard monitor (R4, R6, R7)
  always @(negedge clk) begin
    if (rst_n && core_valid && core_ready) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R6 unexpected word got=%h exp=none", core_data);
      end else begin
        logic [36:0] e;
        e = exp_q.pop_front();
        if ({core_last, core_ben, core_data} !== e) begin
          n_bad++;
          $display("FAIL R4/R7 word got=%h exp=%h", {core_last, core_ben, core_data}, e);
        end
      end
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog got=timeout exp=finish");
    summary();
  end

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] v);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 0;
    v = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(req, v, exp);
  endtask

  task automatic set_len(input logic [31:0] hi, input logic [31:0] lo);
    bus_write(5'h04, hi);
    bus_write(5'h08, lo);
    m_bits = {hi, lo};
  endtask

  task automatic cfg(input int ord, input int alg);
    bus_write(5'h0C, (ord << 8) | alg);
    m_cfg = 1; m_ord = ord;
    m_rem = (m_bits + 7) / 8;
  endtask

  task automatic expect_word(input logic [31:0] w);
    logic [3:0] ben;
    if (!m_hold && m_cfg && m_rem > 0) begin
      ben = (m_rem >= 4) ? 4'hF : 4'((1 << m_rem) - 1);
      exp_q.push_back({(m_rem <= 4), ben, ref_swap(m_ord, w)});
      m_rem = (m_rem >= 4) ? m_rem - 4 : 0;
    end
  endtask

  task automatic send(input logic [31:0] w);
    bit hs;
    expect_word(w);
    dat_valid = 1; dat_word = w;
    do begin
      @(negedge clk); hs = dat_ready;
      @(posedge clk); #1;
    end while (!hs);
    dat_valid = 0;
  endtask

  task automatic give_dig(input logic [31:0] base);
    bit hs;
    for (int i = 0; i < 8; i++) dig_words[32*i +: 32] = base + i;
    dig_valid = 1;
    do begin
      @(negedge clk); hs = dig_ready;
      @(posedge clk); #1;
    end while (!hs);
    dig_valid = 0;
  endtask

  task automatic drain(input string req, input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) rd_chk(req, 5'h1C, base + i);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 irq", irq, 0);
    check("R1 core_valid", core_valid, 0);
    check("R9 dig_ready empty", dig_ready, 1);
    @(posedge clk); #1;
    rd_chk("R1 status", 5'h10, 0);
    rd_chk("R1 control", 5'h0C, 0);

    // data before configuration
    send(32'h1111_2222);
    rd_chk("R8 early write", 5'h10, 32'h8);
    bus_write(5'h14, 32'h8);
    check("R12 irq on", irq, 1);
    rd_chk("R12 status bit8", 5'h10, 32'h108);
    bus_write(5'h18, 32'h8);
    check("R12 irq off", irq, 0);
    rd_chk("R11 cleared", 5'h10, 0);
    bus_write(5'h14, 32'h0);

    // 80 bits = 10 bytes, guard after control write
    set_len(0, 80);
    rd_chk("R3 len low", 5'h08, 80);
    cfg(0, 3);
    check("R4 core_algo", core_algo, 3);
    expect_word(32'hA1B2_C3D4);
    dat_valid = 1; dat_word = 32'hA1B2_C3D4;
    @(negedge clk); check("R5 guard cycle 1", dat_ready, 0);
    @(posedge clk); #1;
    @(negedge clk); check("R5 guard cycle 2", dat_ready, 0);
    @(posedge clk); #1;
    @(negedge clk); check("R5 guard over", dat_ready, 1);
    @(posedge clk); #1;
    dat_valid = 0;
    bp_on = 1;
    send(32'h0506_0708);
    send(32'h0A0B_0C0D);
    send(32'hDEAD_BEEF);
    rd_chk("R8 past length", 5'h10, 32'h8);
    bus_write(5'h18, 32'h8);

    // lane orders with 8-byte messages
    set_len(0, 64);
    for (int o = 1; o < 4; o++) begin
      cfg(o, 0);
      send(32'h1122_3344 + o);
      send(32'h5566_7788 + o);
    end
    set_len(0, 7);
    cfg(2, 0);
    send(32'hCAFE_F00D);
    set_len(1, 0);
    cfg(1, 0);
    send(32'h0102_0304);
    rd_chk("R3 no error in long message", 5'h10, 0);
    bp_on = 0;

    // digests for each algorithm
    bus_write(5'h14, 32'h2);
    for (int a = 0; a < 4; a++) begin
      int n;
      n = (a == 0) ? 4 : (a == 1) ? 5 : (a == 2) ? 7 : 8;
      cfg(0, a);
      give_dig(32'hA000_0000 + (a << 8));
      check("R9 dig_ready low when full", dig_ready, 0);
      check("R12 irq new result", irq, 1);
      rd_chk("R11 status loaded", 5'h10, 32'h103);
      drain("R9 digest word", 32'hA000_0000 + (a << 8), n);
      rd_chk("R11 avail cleared", 5'h10, 32'h102);
      bus_write(5'h18, 32'h2);
      check("R12 irq cleared", irq, 0);
      rd_chk("R10 empty read data", 5'h1C, 0);
      rd_chk("R10 empty read flag", 5'h10, 32'h4);
      bus_write(5'h18, 32'h4);
    end
    bus_write(5'h14, 32'h0);

    // clear and digest load in one cycle
    give_dig(32'hB000_0000);
    drain("R9 digest word", 32'hB000_0000, 8);
    bus_sel = 1; bus_wr = 1; bus_addr = 5'h18; bus_wdata = 32'h2;
    for (int i = 0; i < 8; i++) dig_words[32*i +: 32] = 32'hC000_0000 + i;
    dig_valid = 1;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; dig_valid = 0;
    rd_chk("R11 set wins over clear", 5'h10, 32'h3);
    drain("R9 digest word", 32'hC000_0000, 8);
    bus_write(5'h18, 32'h2);
    rd_chk("R11 plain clear", 5'h10, 0);

    // empty read and digest load in one cycle
    bus_sel = 1; bus_wr = 0; bus_addr = 5'h1C;
    for (int i = 0; i < 8; i++) dig_words[32*i +: 32] = 32'hD000_0000 + i;
    dig_valid = 1;
    @(posedge clk); #1;
    bus_sel = 0; dig_valid = 0;
    check("R10 read while loading", bus_rdata, 0);
    rd_chk("R10 flags after joint cycle", 5'h10, 32'h7);
    drain("R9 digest word", 32'hD000_0000, 8);
    bus_write(5'h18, 32'h6);

    // read data hold
    rd_chk("R13 control read", 5'h0C, 32'h3);
    @(posedge clk); #1;
    check("R13 rdata held", bus_rdata, 32'h3);

    // soft reset
    bus_write(5'h00, 32'h1);
    m_hold = 1;
    bus_write(5'h0C, 32'h101);
    rd_chk("R2 control write ignored", 5'h0C, 0);
    rd_chk("R2 reset bit", 5'h00, 1);
    send(32'h7777_8888);
    rd_chk("R2 no error while held", 5'h10, 0);
    check("R2 dig_ready held low", dig_ready, 0);
    rd_chk("R2 queue read while held", 5'h1C, 0);
    rd_chk("R2 no read error while held", 5'h10, 0);
    bus_write(5'h00, 32'h0);
    m_hold = 0; m_cfg = 0;
    rd_chk("R1 status after release", 5'h10, 0);
    rd_chk("R1 length after release", 5'h08, 0);
    send(32'h9999_AAAA);
    rd_chk("R8 unconfigured after release", 5'h10, 32'h8);

    repeat (4) @(posedge clk);
    check("R6 all words delivered", exp_q.size(), 0);
    summary();
  end

endmodule